// File: doc/BRIEF.md
# FIFO Interrupt and DMA Request Controller

This block turns FIFO events from a queued converter into interrupt and DMA requests. Six channels each pair a command FIFO with a result FIFO. Every channel holds eight status flags: non-coherency, trigger overrun, pause, end of queue, command underflow, command fill, result overflow and result drain. Six of the flags are set by single-cycle event pulses from the FIFO logic. The command-fill flag sets on any clock where the command FIFO is not full. The result-drain flag sets on any clock where the result FIFO is not empty.

Each flag has an enable bit. A request is raised only when the flag and its enable are both 1. The fill and drain requests also have a routing select. Select 0 sends the request to an interrupt line. Select 1 sends it to a DMA request line. In DMA mode the flag clears itself once the FIFO becomes full (fill) or empty (drain). Software clears flags through a write-one-to-clear register port and reads them back with one cycle of latency. Three error conditions (overflow, underflow and trigger overrun) from all channels are also merged into one combined error interrupt.

Top module: `fifo_req_ctrl`

## Requirements
- R1: After reset, all flags, enables, selects and request outputs are 0, and every register reads back 0.
- R2: A one-cycle pulse on a channel's event input sets the matching flag on that clock edge. The status register shows the flags at these bit positions: 0 non-coherency, 1 trigger overrun, 2 pause, 3 end of queue, 4 command underflow, 5 command fill, 6 result overflow, 7 result drain.
- R3: A write to a status register clears each flag whose data bit is 1 and whose byte enable is set. A data bit of 0, or a cleared byte enable, leaves the flag unchanged.
- R4: Each per-condition interrupt output equals flag AND enable, registered, so it changes one clock after the flag. With the enable at 0, the output stays 0.
- R5: Command-fill and result-drain requests drive the interrupt output when their select is 0, and the DMA output when their select is 1. The DMA output follows the flag in the same cycle as the flag.
- R6: With drain routed to DMA, the drain flag clears on the first clock edge on which the channel's result FIFO is empty.
- R7: With fill routed to DMA, the fill flag clears on the first clock edge on which the channel's command FIFO is full.
- R8: If a hardware event and a software clear of the same flag fall on the same clock edge, the flag ends up set.
- R9: The combined error interrupt is the registered OR of the enabled trigger-overrun, command-underflow and result-overflow requests of all channels.
- R10: The command-fill flag sets on any clock edge where the command FIFO is not full. The result-drain flag sets on any clock edge where the result FIFO is not empty.
- R11: The register map uses address = 2 × channel + kind. Kind 0 is control: enables at bits 7:0 in flag order, fill select at bit 8, drain select at bit 9. Kind 1 is status. Read data appears one clock after the read request. Addresses beyond the last channel read 0.
- R12: Channels are independent: events, writes and FIFO levels for one channel leave the flags and outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data (clear mask for status) |
| wr_be | input | DATA_W/8 | Byte enables for the write |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, one cycle after rd_en |
| ev_ncoh | input | NUM_CH | Non-coherency event pulses |
| ev_trig_ovr | input | NUM_CH | Trigger overrun event pulses |
| ev_pause | input | NUM_CH | Pause event pulses |
| ev_eoq | input | NUM_CH | End-of-queue event pulses |
| ev_cf_under | input | NUM_CH | Command FIFO underflow pulses |
| ev_rf_over | input | NUM_CH | Result FIFO overflow pulses |
| cf_full | input | NUM_CH | Command FIFO full levels |
| rf_empty | input | NUM_CH | Result FIFO empty levels |
| irq_ncoh | output | NUM_CH | Non-coherency interrupts |
| irq_trig_ovr | output | NUM_CH | Trigger overrun interrupts |
| irq_pause | output | NUM_CH | Pause interrupts |
| irq_eoq | output | NUM_CH | End-of-queue interrupts |
| irq_cf_under | output | NUM_CH | Command underflow interrupts |
| irq_cfill | output | NUM_CH | Command fill interrupts |
| irq_rf_over | output | NUM_CH | Result overflow interrupts |
| irq_rdrain | output | NUM_CH | Result drain interrupts |
| irq_err | output | 1 | Combined error interrupt |
| dma_cfill | output | NUM_CH | Command fill DMA requests |
| dma_rdrain | output | NUM_CH | Result drain DMA requests |

## Verification
The assertions assume the event inputs are single-cycle pulses that may arrive at any time, even in the same cycle as a software clear. They also assume the FIFO full and empty levels are sampled every clock. The self-clearing checks rely on the select register being stable across the edge being observed, and the bench changes selects only through register writes made while the FIFO levels are idle. The bench holds every command FIFO full and every result FIFO empty unless a fill or drain scenario is running, so the continuous fill and drain set conditions cannot leak into the status values expected by the other scenarios.

// File: rtl/fifo_req_pkg.sv
// Shared constants and types for the FIFO interrupt and DMA request controller.
// Assumes eight conditions per channel; the bit order below is the status layout.
package fifo_req_pkg;
    localparam int NUM_COND = 8;
    localparam int CTL_W    = 10;

    localparam int F_NCOH   = 0;
    localparam int F_TOVR   = 1;
    localparam int F_PAUSE  = 2;
    localparam int F_EOQ    = 3;
    localparam int F_CUND   = 4;
    localparam int F_CFILL  = 5;
    localparam int F_ROVR   = 6;
    localparam int F_RDRAIN = 7;

    localparam int SEL_CFILL_BIT  = 8;
    localparam int SEL_RDRAIN_BIT = 9;

    typedef logic [NUM_COND-1:0] cond_vec_t;

    // Conditions set by event pulses.
    localparam cond_vec_t PULSE_MASK = cond_vec_t'(8'b0101_1111);
    // Conditions merged into the combined error interrupt.
    localparam cond_vec_t ERR_MASK   = cond_vec_t'(8'b0101_0010);
endpackage

// File: rtl/fifo_req_chan.sv
// One channel: the status flags, the enables and the two routing selects.
// Assumes ev_pulse is a one-cycle pulse per event and FIFO levels are synchronous.
// A hardware set always beats a software clear of the same flag in the same cycle.
module fifo_req_chan
    import fifo_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cond_vec_t        ev_pulse,
    input  logic             cf_full,
    input  logic             rf_empty,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [CTL_W-1:0] ctl_wmask,
    input  cond_vec_t        st_clr,
    output cond_vec_t        flag_q,
    output cond_vec_t        en_q,
    output logic             sel_cfill_q,
    output logic             sel_rdrain_q,
    output cond_vec_t        irq_req,
    output logic             dma_cfill,
    output logic             dma_rdrain
);
    cond_vec_t hw_set;
    cond_vec_t sw_clr;
    cond_vec_t auto_clr;
    cond_vec_t flag_d;

    // Control register: masked update of enables and selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q         <= '0;
            sel_cfill_q  <= 1'b0;
            sel_rdrain_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q <= (en_q & ~ctl_wmask[NUM_COND-1:0]) | (ctl_wdata[NUM_COND-1:0] & ctl_wmask[NUM_COND-1:0]);
            if (ctl_wmask[SEL_CFILL_BIT])  sel_cfill_q  <= ctl_wdata[SEL_CFILL_BIT];
            if (ctl_wmask[SEL_RDRAIN_BIT]) sel_rdrain_q <= ctl_wdata[SEL_RDRAIN_BIT];
        end
    end

    // Next flag value: sets beat clears; DMA-routed flags ignore software and self-clear.
    always_comb begin
        hw_set           = ev_pulse & PULSE_MASK;
        hw_set[F_CFILL]  = ~cf_full;
        hw_set[F_RDRAIN] = ~rf_empty;

        sw_clr = st_clr;
        if (sel_cfill_q)  sw_clr[F_CFILL]  = 1'b0;
        if (sel_rdrain_q) sw_clr[F_RDRAIN] = 1'b0;

        auto_clr           = '0;
        auto_clr[F_CFILL]  = sel_cfill_q & cf_full;
        auto_clr[F_RDRAIN] = sel_rdrain_q & rf_empty;

        flag_d = hw_set | (flag_q & ~sw_clr & ~auto_clr);
    end

    // Status flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // Request routing: fill and drain go to DMA when their select is 1.
    always_comb begin
        irq_req           = flag_q & en_q;
        irq_req[F_CFILL]  = flag_q[F_CFILL]  & en_q[F_CFILL]  & ~sel_cfill_q;
        irq_req[F_RDRAIN] = flag_q[F_RDRAIN] & en_q[F_RDRAIN] & ~sel_rdrain_q;
        dma_cfill         = flag_q[F_CFILL]  & en_q[F_CFILL]  & sel_cfill_q;
        dma_rdrain        = flag_q[F_RDRAIN] & en_q[F_RDRAIN] & sel_rdrain_q;
    end

    assert_pulse_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_pulse & PULSE_MASK) != '0) |=>
        ((flag_q & $past(ev_pulse & PULSE_MASK)) == $past(ev_pulse & PULSE_MASK)));

    assert_no_spurious_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_clr == '0) && !sel_cfill_q && !sel_rdrain_q) |=>
        ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_dma_drain_autoclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rdrain_q && rf_empty) |=> !flag_q[F_RDRAIN]);

    assert_dma_fill_autoclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cfill_q && cf_full) |=> !flag_q[F_CFILL]);
endmodule

// File: rtl/fifo_req_regport.sv
// Register port: decodes writes into per-channel control updates and clear masks,
// and returns read data one cycle after rd_en. Assumes DATA_W >= 16, a multiple of 8.
module fifo_req_regport
    import fifo_req_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/8-1:0]      wr_be,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_CH-1:0]        ctl_wr,
    output logic [CTL_W-1:0]         ctl_wdata,
    output logic [CTL_W-1:0]         ctl_wmask,
    output cond_vec_t [NUM_CH-1:0]   st_clr,
    input  cond_vec_t [NUM_CH-1:0]   flags,
    input  cond_vec_t [NUM_CH-1:0]   enables,
    input  logic [NUM_CH-1:0]        sel_cfill,
    input  logic [NUM_CH-1:0]        sel_rdrain
);
    localparam int BE_W = DATA_W / 8;
    localparam int CH_W = ADDR_W - 1;

    logic [DATA_W-1:0] bmask;
    logic [CH_W-1:0]   wr_ch;
    logic [CH_W-1:0]   rd_ch;
    logic [DATA_W-1:0] rd_word;

    assign wr_ch = wr_addr[ADDR_W-1:1];
    assign rd_ch = rd_addr[ADDR_W-1:1];

    // Expand byte enables into a bit mask.
    for (genvar b = 0; b < BE_W; b++) begin : g_bmask
        assign bmask[b*8 +: 8] = {8{wr_be[b]}};
    end

    assign ctl_wdata = wr_data[CTL_W-1:0];
    assign ctl_wmask = bmask[CTL_W-1:0];

    // Write decode: control update strobe or status clear mask for the addressed channel.
    always_comb begin
        ctl_wr = '0;
        st_clr = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && (wr_ch == CH_W'(c))) begin
                if (wr_addr[0]) st_clr[c] = wr_data[NUM_COND-1:0] & bmask[NUM_COND-1:0];
                else            ctl_wr[c] = 1'b1;
            end
        end
    end

    // Read mux: status or control word of the addressed channel, 0 when out of range.
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c)) begin
                if (rd_addr[0]) begin
                    rd_word[NUM_COND-1:0] = flags[c];
                end else begin
                    rd_word[NUM_COND-1:0]  = enables[c];
                    rd_word[SEL_CFILL_BIT]  = sel_cfill[c];
                    rd_word[SEL_RDRAIN_BIT] = sel_rdrain[c];
                end
            end
        end
    end

    // Read data register: one cycle of latency, holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end
endmodule

// File: rtl/fifo_req_irq.sv
// Interrupt output stage: registers every per-channel request and the combined
// error request. Assumes irq_req already includes enable and routing.
module fifo_req_irq
    import fifo_req_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cond_vec_t [NUM_CH-1:0] irq_req,
    output cond_vec_t [NUM_CH-1:0] irq_q,
    output logic                   err_q
);
    logic err_any;

    // OR of the error-class requests across all channels.
    always_comb begin
        err_any = 1'b0;
        for (int c = 0; c < NUM_CH; c++) err_any = err_any | (|(irq_req[c] & ERR_MASK));
    end

    // Output registers for all interrupt lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            err_q <= 1'b0;
        end else begin
            irq_q <= irq_req;
            err_q <= err_any;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_err_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ((irq_q[c] & ERR_MASK) != '0) |-> err_q);
    end
endmodule

// File: rtl/fifo_req_ctrl.sv
// Top: six-channel FIFO interrupt and DMA request controller. Gathers event
// inputs per channel, instantiates the channel logic, register port and
// interrupt stage. Assumes all inputs are synchronous to clk.
module fifo_req_ctrl
    import fifo_req_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_CH-1:0]   ev_ncoh,
    input  logic [NUM_CH-1:0]   ev_trig_ovr,
    input  logic [NUM_CH-1:0]   ev_pause,
    input  logic [NUM_CH-1:0]   ev_eoq,
    input  logic [NUM_CH-1:0]   ev_cf_under,
    input  logic [NUM_CH-1:0]   ev_rf_over,
    input  logic [NUM_CH-1:0]   cf_full,
    input  logic [NUM_CH-1:0]   rf_empty,
    output logic [NUM_CH-1:0]   irq_ncoh,
    output logic [NUM_CH-1:0]   irq_trig_ovr,
    output logic [NUM_CH-1:0]   irq_pause,
    output logic [NUM_CH-1:0]   irq_eoq,
    output logic [NUM_CH-1:0]   irq_cf_under,
    output logic [NUM_CH-1:0]   irq_cfill,
    output logic [NUM_CH-1:0]   irq_rf_over,
    output logic [NUM_CH-1:0]   irq_rdrain,
    output logic                irq_err,
    output logic [NUM_CH-1:0]   dma_cfill,
    output logic [NUM_CH-1:0]   dma_rdrain
);
    logic [NUM_CH-1:0]      ctl_wr;
    logic [CTL_W-1:0]       ctl_wdata;
    logic [CTL_W-1:0]       ctl_wmask;
    cond_vec_t [NUM_CH-1:0] st_clr;
    cond_vec_t [NUM_CH-1:0] flags;
    cond_vec_t [NUM_CH-1:0] enables;
    logic [NUM_CH-1:0]      sel_cfill;
    logic [NUM_CH-1:0]      sel_rdrain;
    cond_vec_t [NUM_CH-1:0] irq_req;
    cond_vec_t [NUM_CH-1:0] irq_q;

    fifo_req_regport #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regport (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_wmask(ctl_wmask), .st_clr(st_clr),
        .flags(flags), .enables(enables), .sel_cfill(sel_cfill), .sel_rdrain(sel_rdrain)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cond_vec_t ev_vec;

        // Gather this channel's event pulses into condition order.
        always_comb begin
            ev_vec          = '0;
            ev_vec[F_NCOH]  = ev_ncoh[c];
            ev_vec[F_TOVR]  = ev_trig_ovr[c];
            ev_vec[F_PAUSE] = ev_pause[c];
            ev_vec[F_EOQ]   = ev_eoq[c];
            ev_vec[F_CUND]  = ev_cf_under[c];
            ev_vec[F_ROVR]  = ev_rf_over[c];
        end

        fifo_req_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .ev_pulse(ev_vec), .cf_full(cf_full[c]), .rf_empty(rf_empty[c]),
            .ctl_wr(ctl_wr[c]), .ctl_wdata(ctl_wdata), .ctl_wmask(ctl_wmask),
            .st_clr(st_clr[c]),
            .flag_q(flags[c]), .en_q(enables[c]),
            .sel_cfill_q(sel_cfill[c]), .sel_rdrain_q(sel_rdrain[c]),
            .irq_req(irq_req[c]), .dma_cfill(dma_cfill[c]), .dma_rdrain(dma_rdrain[c])
        );

        assign irq_ncoh[c]     = irq_q[c][F_NCOH];
        assign irq_trig_ovr[c] = irq_q[c][F_TOVR];
        assign irq_pause[c]    = irq_q[c][F_PAUSE];
        assign irq_eoq[c]      = irq_q[c][F_EOQ];
        assign irq_cf_under[c] = irq_q[c][F_CUND];
        assign irq_cfill[c]    = irq_q[c][F_CFILL];
        assign irq_rf_over[c]  = irq_q[c][F_ROVR];
        assign irq_rdrain[c]   = irq_q[c][F_RDRAIN];
    end

    fifo_req_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_q(irq_q), .err_q(irq_err)
    );
endmodule

// File: tb/fifo_req_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module fifo_req_ctrl_tb;
    localparam int NUM_CH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [5:0]  ev_ncoh = '0, ev_trig_ovr = '0, ev_pause = '0, ev_eoq = '0;
    logic [5:0]  ev_cf_under = '0, ev_rf_over = '0;
    logic [5:0]  cf_full = '1, rf_empty = '1;
    logic [5:0]  irq_ncoh, irq_trig_ovr, irq_pause, irq_eoq, irq_cf_under;
    logic [5:0]  irq_cfill, irq_rf_over, irq_rdrain, dma_cfill, dma_rdrain;
    logic        irq_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fifo_req_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_ncoh(ev_ncoh), .ev_trig_ovr(ev_trig_ovr), .ev_pause(ev_pause), .ev_eoq(ev_eoq),
        .ev_cf_under(ev_cf_under), .ev_rf_over(ev_rf_over),
        .cf_full(cf_full), .rf_empty(rf_empty),
        .irq_ncoh(irq_ncoh), .irq_trig_ovr(irq_trig_ovr), .irq_pause(irq_pause),
        .irq_eoq(irq_eoq), .irq_cf_under(irq_cf_under), .irq_cfill(irq_cfill),
        .irq_rf_over(irq_rf_over), .irq_rdrain(irq_rdrain), .irq_err(irq_err),
        .dma_cfill(dma_cfill), .dma_rdrain(dma_rdrain)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data, input logic [3:0] be);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        rd_en = 1'b1; rd_addr = 4'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        data = rd_data;
    endtask

    function automatic int st(input int ch); return 2 * ch + 1; endfunction
    function automatic int ct(input int ch); return 2 * ch; endfunction

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq lines", {irq_ncoh, irq_trig_ovr, irq_pause, irq_eoq, irq_cf_under,
                             irq_cfill, irq_rf_over, irq_rdrain}, 0);
        chk("R1 dma/err", {dma_cfill, dma_rdrain, irq_err}, 0);
        rd(st(0), v); chk("R1 status ch0", v, 0);
        rd(ct(5), v); chk("R1 control ch5", v, 0);
    endtask

    task automatic t_pulse_flags;
        logic [31:0] v;
        ev_ncoh[2] = 1; ev_pause[2] = 1; ev_rf_over[2] = 1;
        ev_eoq[5] = 1; ev_trig_ovr[5] = 1; ev_cf_under[5] = 1;
        @(negedge clk);
        ev_ncoh = '0; ev_pause = '0; ev_rf_over = '0; ev_eoq = '0; ev_trig_ovr = '0; ev_cf_under = '0;
        rd(st(2), v); chk("R2 status ch2", v, 32'h45);
        rd(st(5), v); chk("R2 status ch5", v, 32'h1A);
        rd(st(3), v); chk("R12 status ch3 untouched", v, 0);
        rd(14, v);    chk("R11 out-of-range address", v, 0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(st(2), 32'h04, 4'h1); rd(st(2), v); chk("R3 clear bit 2", v, 32'h41);
        wr(st(2), 32'h41, 4'h2); rd(st(2), v); chk("R3 byte enable off", v, 32'h41);
        wr(st(2), 32'h00, 4'hF); rd(st(2), v); chk("R3 zero write", v, 32'h41);
        rd(st(5), v); chk("R12 ch5 kept", v, 32'h1A);
        wr(st(2), 32'hFF, 4'hF); rd(st(2), v); chk("R3 clear all", v, 0);
        wr(st(5), 32'hFF, 4'hF); rd(st(5), v); chk("R3 clear ch5", v, 0);
    endtask

    task automatic t_irq_enable;
        logic [31:0] v;
        wr(ct(1), 32'h001, 4'h3);
        rd(ct(1), v); chk("R11 control read", v, 32'h001);
        ev_ncoh[1] = 1; ev_pause[1] = 1;
        @(negedge clk);
        ev_ncoh = '0; ev_pause = '0;
        chk("R4 irq one cycle late", 32'(irq_ncoh), 0);
        @(negedge clk);
        chk("R4 irq ncoh ch1", 32'(irq_ncoh), 32'h02);
        chk("R4 pause disabled", 32'(irq_pause), 0);
        wr(st(1), 32'h05, 4'h1);
        @(negedge clk);
        chk("R4 irq drops after clear", 32'(irq_ncoh), 0);
    endtask

    task automatic t_err;
        ev_trig_ovr[4] = 1;
        @(negedge clk); ev_trig_ovr = '0;
        @(negedge clk);
        chk("R9 disabled overrun no err", {31'b0, irq_err}, 0);
        wr(st(4), 32'hFF, 4'h1);
        wr(ct(3), 32'h052, 4'h1);
        ev_cf_under[3] = 1;
        @(negedge clk); ev_cf_under = '0;
        @(negedge clk);
        chk("R9 err on underflow", {31'b0, irq_err}, 1);
        chk("R9 underflow line", 32'(irq_cf_under), 32'h08);
        wr(st(3), 32'h10, 4'h1);
        @(negedge clk);
        chk("R9 err clears", {31'b0, irq_err}, 0);
        ev_rf_over[3] = 1;
        @(negedge clk); ev_rf_over = '0;
        @(negedge clk);
        chk("R9 err on overflow", {31'b0, irq_err}, 1);
        wr(st(3), 32'h40, 4'h1);
    endtask

    task automatic t_fill;
        logic [31:0] v;
        wr(ct(0), 32'h020, 4'h3);
        cf_full[0] = 0;
        @(negedge clk);
        cf_full[0] = 1;
        rd(st(0), v); chk("R10 fill flag set while not full", v, 32'h20);
        chk("R5 irq fill routed", 32'(irq_cfill), 32'h01);
        chk("R5 no dma in irq mode", 32'(dma_cfill), 0);
        rd(st(0), v); chk("R7 irq mode keeps flag when full", v, 32'h20);
        wr(st(0), 32'h20, 4'h1);
        rd(st(0), v); chk("R3 fill cleared by software", v, 0);
        wr(ct(0), 32'h120, 4'h3);
        cf_full[0] = 0;
        @(negedge clk);
        chk("R5 dma fill same cycle as flag", 32'(dma_cfill), 32'h01);
        @(negedge clk);
        chk("R5 no irq in dma mode", 32'(irq_cfill), 0);
        cf_full[0] = 1;
        @(negedge clk);
        chk("R7 dma fill drops when full", 32'(dma_cfill), 0);
        rd(st(0), v); chk("R7 fill flag auto-cleared", v, 0);
        wr(ct(0), 32'h000, 4'h3);
    endtask

    task automatic t_drain;
        logic [31:0] v;
        wr(ct(4), 32'h280, 4'h3);
        rf_empty[4] = 0;
        @(negedge clk);
        chk("R5 dma drain", 32'(dma_rdrain), 32'h10);
        chk("R12 other channels no dma", 32'(dma_cfill), 0);
        @(negedge clk);
        chk("R5 no drain irq in dma mode", 32'(irq_rdrain), 0);
        rf_empty[4] = 1;
        @(negedge clk);
        chk("R6 dma drain drops when empty", 32'(dma_rdrain), 0);
        rd(st(4), v); chk("R6 drain flag auto-cleared", v, 0);
        wr(ct(4), 32'h080, 4'h3);
        rf_empty[4] = 0;
        @(negedge clk);
        rf_empty[4] = 1;
        @(negedge clk);
        chk("R5 drain irq routed", 32'(irq_rdrain), 32'h10);
        chk("R5 no dma in irq mode", 32'(dma_rdrain), 0);
        rd(st(4), v); chk("R10 drain flag held", v, 32'h80);
        wr(st(4), 32'h80, 4'h1);
        rd(st(4), v); chk("R3 drain cleared", v, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        ev_eoq[5] = 1;
        @(negedge clk);
        ev_eoq[5] = 1; wr_en = 1; wr_addr = 4'(st(5)); wr_data = 32'h08; wr_be = 4'h1;
        @(negedge clk);
        ev_eoq = '0; wr_en = 0; wr_be = '0;
        rd(st(5), v); chk("R8 set beats clear", v, 32'h08);
        wr(st(5), 32'h08, 4'h1);
        rd(st(5), v); chk("R8 later clear works", v, 0);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulse_flags();
        t_w1c();
        t_irq_enable();
        t_err();
        t_fill();
        t_drain();
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule